// File: doc/BRIEF.md
# Multi-Thread Instruction Queue Fetch

This block keeps a small instruction queue for each of several hardware threads and keeps those queues filled from an instruction cache. Each thread owns two queue slots. A slot holds one cache line of four instructions. A thread starts fetching when it receives a redirect, which carries a line pointer. It then requests that line and, as soon as its other slot is free, prefetches the line that follows. The issue logic drains each thread through its own read port, one instruction at a time and in program order.

Fetches from different threads go to the cache through a single request channel. A shared table records every line that is outstanding. Each table entry carries one waiting bit for each (thread, slot) pair. When a thread asks for a line that is already in flight, the block sets that thread's bit in the existing entry and sends nothing new. A single returned line is then written into every slot that waits for it.

When several threads want a fetch in the same cycle, the oldest waiter wins. A thread whose queue is completely empty goes ahead of threads that are only prefetching. A redirect flushes the thread's slots and withdraws its waiting bits, so data that comes back later for the old path never reaches its queue.

Top module: `mt_ifetch_queue`

## Requirements
- R1: After reset, `req_valid` and every `rd_valid` bit are low, and no thread fetches until it receives a redirect.
- R2: After a redirect to line L, a thread's read port delivers words 0..3 of L, then words 0..3 of L+1, and so on. Word w of a line is bits [w*128 +: 128] of `rsp_data`. Each word moves on a cycle where both `rd_valid` and `rd_ready` are high.
- R3: A line is never requested while a request for that same line is outstanding. The table never holds two valid entries for the same line. A return fills every slot that waits on the line.
- R4: At most NE lines are outstanding at once. While the table is full, new misses are held back.
- R5: A redirect empties the thread's queue: `rd_valid` is low in the following cycle. A read handshake in the redirect cycle is discarded. Returns for lines requested before the redirect are never delivered to that thread.
- R6: Among threads that are ready to fetch, those with both slots empty win over those that are prefetching. Within one class, the thread that has waited longest wins. Threads that start waiting in the same cycle are ordered lowest index first. A thread's waiting time restarts after each grant.
- R7: The request channel is valid/ready. Once `req_valid` is high, it stays high and `req_line` holds its value until `req_ready` is seen high.
- R8: Returns are always accepted. A return whose line is not outstanding has no effect.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_instr` holds its value (when there is no redirect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_vld | input | NT | One bit per thread: flush and restart at `redir_ip` |
| redir_ip | input | NT*LW | Per-thread line pointer for the redirect |
| req_valid | output | 1 | A fetch request is presented to the cache |
| req_ready | input | 1 | The cache takes the request |
| req_line | output | LW | Line pointer of the request |
| rsp_valid | input | 1 | A cache line is returned (always accepted) |
| rsp_line | input | LW | Line pointer of the returned line |
| rsp_data | input | WPL*IW | Returned line, word w at bits [w*IW +: IW] |
| rd_valid | output | NT | Per-thread: the head instruction is available |
| rd_ready | input | NT | Per-thread: the issue logic takes the head instruction |
| rd_instr | output | NT*IW | Per-thread head instruction |

## Verification
The bench uses the default parameters: eight threads, four table entries, 26-bit line pointers, and lines of four 128-bit words. With sixteen slots competing for only four entries, the table fills quickly, so the full-table hold-off and the age ordering can be seen in short directed runs. In the random phase, redirect targets are limited to a dozen nearby lines. This makes merges into entries already in flight, stale returns after a flush, and returns that arrive out of order all frequent.

// File: rtl/mtiq_pkg.sv
package mtiq_pkg;
  typedef enum logic [1:0] {
    SL_EMPTY = 2'd0,
    SL_WAIT  = 2'd1,
    SL_FULL  = 2'd2
  } slot_e;
endpackage

// File: rtl/mtiq_thread.sv
module mtiq_thread
  import mtiq_pkg::*;
#(
  parameter int LW  = 26,
  parameter int IW  = 128,
  parameter int WPL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_vld,
  input  logic [LW-1:0]     redir_ip,
  input  logic              grant,
  input  logic [1:0]        fill_mask,
  input  logic [WPL*IW-1:0] fill_data,
  input  logic              rd_ready,
  output logic              want,
  output logic              demand,
  output logic [LW-1:0]     fetch_ip,
  output logic              tail_slot,
  output logic              rd_valid,
  output logic [IW-1:0]     rd_instr
);
  localparam int LNW = WPL * IW;
  localparam int WIW = $clog2(WPL);

  slot_e            st_q   [2];
  logic [LNW-1:0]   line_q [2];
  logic             hd_q, tl_q, run_q;
  logic [WIW-1:0]   wi_q;
  logic [LW-1:0]    fip_q;

  assign want      = run_q && (st_q[tl_q] == SL_EMPTY);
  assign demand    = run_q && (st_q[0] == SL_EMPTY) && (st_q[1] == SL_EMPTY);
  assign fetch_ip  = fip_q;
  assign tail_slot = tl_q;
  assign rd_valid  = (st_q[hd_q] == SL_FULL);
  assign rd_instr  = line_q[hd_q][int'(wi_q)*IW +: IW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      hd_q    <= 1'b0;
      tl_q    <= 1'b0;
      wi_q    <= '0;
      fip_q   <= '0;
      st_q[0] <= SL_EMPTY;
      st_q[1] <= SL_EMPTY;
    end else if (redir_vld) begin
      run_q   <= 1'b1;
      hd_q    <= 1'b0;
      tl_q    <= 1'b0;
      wi_q    <= '0;
      fip_q   <= redir_ip;
      st_q[0] <= SL_EMPTY;
      st_q[1] <= SL_EMPTY;
    end else begin
      if (grant) begin
        st_q[tl_q] <= SL_WAIT;
        tl_q       <= ~tl_q;
        fip_q      <= fip_q + LW'(1);
      end
      for (int s = 0; s < 2; s++) begin
        if (fill_mask[s] && st_q[s] == SL_WAIT) st_q[s] <= SL_FULL;
      end
      if (rd_valid && rd_ready) begin
        if (wi_q == WIW'(WPL - 1)) begin
          st_q[hd_q] <= SL_EMPTY;
          hd_q       <= ~hd_q;
          wi_q       <= '0;
        end else begin
          wi_q <= wi_q + WIW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (fill_mask[s] && st_q[s] == SL_WAIT && !redir_vld) line_q[s] <= fill_data;
    end
  end

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |=> !rd_valid);
  assert_head_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !redir_vld) |=> (rd_valid && $stable(rd_instr)));
  assert_grant_needs_want_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> want);
endmodule

// File: rtl/mtiq_age_arb.sv
module mtiq_age_arb #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] want,
  input  logic [N-1:0] elig,
  input  logic [N-1:0] urgent,
  output logic [N-1:0] gnt
);
  logic [N-1:0] older_q [N];
  logic [N-1:0] eff     [N];
  logic [N-1:0] want_q, gnt_q, fresh, cand;

  assign fresh = want & (~want_q | gnt_q);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i == j)                  eff[i][j] = 1'b0;
        else if (fresh[i] && fresh[j]) eff[i][j] = (i < j);
        else if (fresh[i])           eff[i][j] = 1'b0;
        else if (fresh[j])           eff[i][j] = 1'b1;
        else                         eff[i][j] = older_q[i][j];
      end
    end
    cand = elig & urgent;
    if (cand == '0) cand = elig;
    for (int i = 0; i < N; i++) begin
      gnt[i] = cand[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && cand[j] && !eff[i][j]) gnt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      gnt_q  <= '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) older_q[i][j] <= (i < j);
    end else begin
      want_q <= want;
      gnt_q  <= gnt;
      for (int i = 0; i < N; i++) older_q[i] <= eff[i];
    end
  end

  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_urgent_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(elig & urgent)) |-> (|(gnt & urgent)));
endmodule

// File: rtl/mtiq_otab.sv
module mtiq_otab #(
  parameter int NT = 8,
  parameter int NE = 4,
  parameter int LW = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NT*LW-1:0]  look_ip,
  output logic [NT-1:0]     hit,
  output logic              full,
  input  logic              claim_vld,
  input  logic [$clog2(NT)-1:0] claim_thr,
  input  logic              claim_slot,
  input  logic [NT-1:0]     flush,
  input  logic              rsp_vld,
  input  logic [LW-1:0]     rsp_line,
  output logic [2*NT-1:0]   fill_mask
);
  localparam int TW = $clog2(NT);
  localparam int EW = $clog2(NE);
  localparam int NB = 2 * NT;

  logic [NE-1:0] vld_q;
  logic [LW-1:0] line_q [NE];
  logic [NB-1:0] bits_q [NE];
  logic [NE-1:0] match  [NT];
  logic [NE-1:0] rsp_kill;
  logic [NB-1:0] flush2, claim_bit;
  logic [EW-1:0] free_idx;
  logic [LW-1:0] claim_ip;
  logic          claim_hit, dup;

  assign full      = &vld_q;
  assign claim_ip  = look_ip[int'(claim_thr)*LW +: LW];
  assign claim_hit = hit[claim_thr];

  always_comb begin
    for (int e = 0; e < NE; e++)
      rsp_kill[e] = rsp_vld && vld_q[e] && (line_q[e] == rsp_line);
    for (int i = 0; i < NT; i++) begin
      for (int e = 0; e < NE; e++)
        match[i][e] = vld_q[e] && !rsp_kill[e] && (line_q[e] == look_ip[i*LW +: LW]);
      hit[i] = |match[i];
      flush2[2*i +: 2] = {2{flush[i]}};
    end
    free_idx = '0;
    for (int e = NE - 1; e >= 0; e--)
      if (!vld_q[e]) free_idx = EW'(e);
    claim_bit = '0;
    claim_bit[2*int'(claim_thr) + int'(claim_slot)] = 1'b1;
    fill_mask = '0;
    for (int e = 0; e < NE; e++)
      if (rsp_kill[e]) fill_mask = fill_mask | bits_q[e];
    fill_mask = fill_mask & ~flush2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < NE; e++) bits_q[e] <= '0;
    end else begin
      for (int e = 0; e < NE; e++) begin
        if (rsp_kill[e]) begin
          vld_q[e]  <= 1'b0;
          bits_q[e] <= '0;
        end else if (claim_vld && !claim_hit && !full && free_idx == EW'(e)) begin
          vld_q[e]  <= 1'b1;
          bits_q[e] <= claim_bit;
        end else if (claim_vld && claim_hit && match[claim_thr][e]) begin
          bits_q[e] <= (bits_q[e] & ~flush2) | claim_bit;
        end else begin
          bits_q[e] <= bits_q[e] & ~flush2;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NE; e++)
      if (!vld_q[e] && claim_vld && !claim_hit && free_idx == EW'(e)) line_q[e] <= claim_ip;
  end

  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < NE; a++)
      for (int b = a + 1; b < NE; b++)
        if (vld_q[a] && vld_q[b] && line_q[a] == line_q[b]) dup = 1'b1;
  end

  assert_no_dup_line_R3: assert property (@(posedge clk) disable iff (!rst_n) !dup);
  assert_alloc_has_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_vld && !claim_hit) |-> !full);
  assert_claim_not_flushed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    claim_vld |-> !flush[claim_thr]);
endmodule

// File: rtl/mt_ifetch_queue.sv
module mt_ifetch_queue #(
  parameter int NT  = 8,
  parameter int NE  = 4,
  parameter int LW  = 26,
  parameter int IW  = 128,
  parameter int WPL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NT-1:0]     redir_vld,
  input  logic [NT*LW-1:0]  redir_ip,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [LW-1:0]     req_line,
  input  logic              rsp_valid,
  input  logic [LW-1:0]     rsp_line,
  input  logic [WPL*IW-1:0] rsp_data,
  output logic [NT-1:0]     rd_valid,
  input  logic [NT-1:0]     rd_ready,
  output logic [NT*IW-1:0]  rd_instr
);
  localparam int TW = $clog2(NT);

  logic [NT-1:0]    want, demand, tail, hit, elig, gnt;
  logic [NT*LW-1:0] fip;
  logic [2*NT-1:0]  fill_mask;
  logic [TW-1:0]    gidx;
  logic             full, out_free, gnt_any;

  for (genvar g = 0; g < NT; g++) begin : g_thr
    mtiq_thread #(.LW(LW), .IW(IW), .WPL(WPL)) u_thr (
      .clk       (clk),
      .rst_n     (rst_n),
      .redir_vld (redir_vld[g]),
      .redir_ip  (redir_ip[g*LW +: LW]),
      .grant     (gnt[g]),
      .fill_mask (fill_mask[2*g +: 2]),
      .fill_data (rsp_data),
      .rd_ready  (rd_ready[g]),
      .want      (want[g]),
      .demand    (demand[g]),
      .fetch_ip  (fip[g*LW +: LW]),
      .tail_slot (tail[g]),
      .rd_valid  (rd_valid[g]),
      .rd_instr  (rd_instr[g*IW +: IW])
    );
  end

  assign out_free = !req_valid || req_ready;
  assign elig     = want & ~redir_vld & (hit | {NT{!full && out_free}});
  assign gnt_any  = |gnt;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NT; i++) if (gnt[i]) gidx = TW'(i);
  end

  mtiq_age_arb #(.N(NT)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .want   (want & ~redir_vld),
    .elig   (elig),
    .urgent (demand),
    .gnt    (gnt)
  );

  mtiq_otab #(.NT(NT), .NE(NE), .LW(LW)) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_ip    (fip),
    .hit        (hit),
    .full       (full),
    .claim_vld  (gnt_any),
    .claim_thr  (gidx),
    .claim_slot (tail[gidx]),
    .flush      (redir_vld),
    .rsp_vld    (rsp_valid),
    .rsp_line   (rsp_line),
    .fill_mask  (fill_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_line  <= '0;
    end else if (gnt_any && !hit[gidx]) begin
      req_valid <= 1'b1;
      req_line  <= fip[int'(gidx)*LW +: LW];
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line)));
  assert_load_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && !hit[gidx]) |-> out_free);
endmodule

// File: tb/tb_mt_ifetch_queue.sv
module tb_mt_ifetch_queue;
  localparam int NT = 8, NE = 4, LW = 26, IW = 128, WPL = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NT-1:0]     redir_vld = '0;
  logic [NT*LW-1:0]  redir_ip = '0;
  logic              req_valid, req_ready = 1'b0;
  logic [LW-1:0]     req_line;
  logic              rsp_valid = 1'b0;
  logic [LW-1:0]     rsp_line = '0;
  logic [WPL*IW-1:0] rsp_data = '0;
  logic [NT-1:0]     rd_valid, rd_ready = '0;
  logic [NT*IW-1:0]  rd_instr;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [LW-1:0] pend_line [64];
  int            pend_n = 0;
  logic [LW-1:0] req_log [64];
  int            req_cnt = 0;
  logic [LW-1:0] exp_line [NT];
  int            exp_w [NT];
  logic [IW-1:0] held;

  always #4 clk = ~clk;

  mt_ifetch_queue #(.NT(NT), .NE(NE), .LW(LW), .IW(IW), .WPL(WPL)) dut (
    .clk(clk), .rst_n(rst_n), .redir_vld(redir_vld), .redir_ip(redir_ip),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_data(rsp_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_instr(rd_instr));

  function automatic logic [IW-1:0] fexp(input logic [LW-1:0] ln, input int w);
    return {32'(ln) * 32'h9E3779B1, 6'd0, ln, 32'(w) ^ 32'h5A5A0000, ~(32'(ln) + 32'(w))};
  endfunction

  function automatic logic [WPL*IW-1:0] mk_line(input logic [LW-1:0] ln);
    logic [WPL*IW-1:0] d;
    for (int w = 0; w < WPL; w++) d[w*IW +: IW] = fexp(ln, w);
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic redirect(input int t, input logic [LW-1:0] ln);
    redir_vld[t] = 1'b1;
    redir_ip[t*LW +: LW] = ln;
  endtask

  task automatic respond(input logic [LW-1:0] ln);
    rsp_valid = 1'b1;
    rsp_line  = ln;
    rsp_data  = mk_line(ln);
  endtask

  // Inputs are set just after a negedge; outputs are sampled 3 ns later, before the posedge.
  task automatic tick();
    #3;
    if (req_valid && req_ready) begin
      int found;
      found = 0;
      for (int k = 0; k < pend_n; k++) if (pend_line[k] == req_line) found = 1;
      chk(found == 0, "R3 request for a line already outstanding", 128'(req_line), 128'(0));
      pend_line[pend_n] = req_line;
      pend_n++;
      if (req_cnt < 64) req_log[req_cnt] = req_line;
      req_cnt++;
      chk(pend_n <= NE, "R4 outstanding lines above table size", 128'(pend_n), 128'(NE));
    end
    if (rsp_valid) begin
      for (int k = 0; k < pend_n; k++) begin
        if (pend_line[k] == rsp_line) begin
          pend_line[k] = pend_line[pend_n - 1];
          pend_n--;
          break;
        end
      end
    end
    for (int i = 0; i < NT; i++) begin
      if (rd_valid[i] && rd_ready[i] && !redir_vld[i]) begin
        chk(rd_instr[i*IW +: IW] == fexp(exp_line[i], exp_w[i]), "R2 read port word",
            rd_instr[i*IW +: IW], fexp(exp_line[i], exp_w[i]));
        exp_w[i]++;
        if (exp_w[i] == WPL) begin
          exp_w[i] = 0;
          exp_line[i] = exp_line[i] + LW'(1);
        end
      end
      if (redir_vld[i]) begin
        exp_line[i] = redir_ip[i*LW +: LW];
        exp_w[i] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    redir_vld = '0;
    rsp_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    redir_vld = '0;
    rsp_valid = 1'b0;
    rd_ready = '0;
    req_ready = 1'b0;
    pend_n = 0;
    req_cnt = 0;
    for (int i = 0; i < NT; i++) begin
      exp_line[i] = '0;
      exp_w[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // R1: reset state and idle threads
    do_reset();
    req_ready = 1'b1;
    ticks(3);
    chk(req_valid == 1'b0, "R1 req_valid after reset", 128'(req_valid), 128'(0));
    chk(rd_valid == '0, "R1 rd_valid after reset", 128'(rd_valid), 128'(0));
    chk(req_cnt == 0, "R1 no fetch before a redirect", 128'(req_cnt), 128'(0));

    // R6 and R4: demand before prefetch, oldest first, table capacity
    do_reset();
    redirect(0, 26'h200); tick();
    ticks(2);
    redirect(5, 26'h300); tick();
    tick();
    redirect(3, 26'h400); tick();
    ticks(3);
    req_ready = 1'b1;
    ticks(10);
    chk(req_cnt == NE, "R4 requests held while table full", 128'(req_cnt), 128'(NE));
    chk(req_log[0] == 26'h200, "R6 first grant", 128'(req_log[0]), 128'(26'h200));
    chk(req_log[1] == 26'h300, "R6 oldest demand thread", 128'(req_log[1]), 128'(26'h300));
    chk(req_log[2] == 26'h400, "R6 younger demand thread", 128'(req_log[2]), 128'(26'h400));
    chk(req_log[3] == 26'h201, "R6 oldest prefetch after demand", 128'(req_log[3]), 128'(26'h201));
    respond(26'h300); tick();
    ticks(5);
    chk(req_cnt == NE + 1, "R4 freed entry reused", 128'(req_cnt), 128'(NE + 1));
    chk(req_log[4] == 26'h301, "R6 oldest prefetch after free", 128'(req_log[4]), 128'(26'h301));

    // R3, R8, R9: merge of a shared line between two threads
    do_reset();
    redirect(1, 26'h500);
    redirect(2, 26'h500);
    tick();
    ticks(6);
    req_ready = 1'b1;
    ticks(6);
    chk(req_cnt == 2, "R3 shared lines requested once", 128'(req_cnt), 128'(2));
    chk(req_log[0] == 26'h500, "R3 first shared line", 128'(req_log[0]), 128'(26'h500));
    chk(req_log[1] == 26'h501, "R3 second shared line", 128'(req_log[1]), 128'(26'h501));
    respond(26'h777); tick();
    tick();
    chk(rd_valid == '0, "R8 return of unrequested line ignored", 128'(rd_valid), 128'(0));
    respond(26'h500); tick();
    chk(rd_valid[1] && rd_valid[2], "R3 one return fills both threads", 128'(rd_valid), 128'(8'h06));
    held = rd_instr[1*IW +: IW];
    tick();
    chk(rd_instr[1*IW +: IW] == held && held == fexp(26'h500, 0), "R9 head held without ready",
        rd_instr[1*IW +: IW], fexp(26'h500, 0));
    rd_ready = 8'h06;
    ticks(5);
    respond(26'h501); tick();
    ticks(6);
    chk(exp_line[1] == 26'h502 && exp_line[2] == 26'h502, "R2 both threads drained two lines",
        128'(exp_line[1]), 128'(26'h502));

    // R5: flush drops stale returns
    do_reset();
    req_ready = 1'b1;
    redirect(7, 26'h600); tick();
    ticks(5);
    redirect(7, 26'h700); tick();
    ticks(4);
    respond(26'h600); tick();
    respond(26'h601); tick();
    tick();
    chk(rd_valid[7] == 1'b0, "R5 stale return not delivered", 128'(rd_valid[7]), 128'(0));
    respond(26'h700); tick();
    tick();
    chk(rd_valid[7] && rd_instr[7*IW +: IW] == fexp(26'h700, 0), "R5 new path first word",
        rd_instr[7*IW +: IW], fexp(26'h700, 0));
    rd_ready[7] = 1'b1;
    redirect(7, 26'h800); tick();
    chk(rd_valid[7] == 1'b0, "R5 queue empty after redirect", 128'(rd_valid[7]), 128'(0));
    rd_ready[7] = 1'b0;
    ticks(4);
    respond(26'h701); tick();
    ticks(3);
    respond(26'h800); tick();
    tick();
    chk(rd_instr[7*IW +: IW] == fexp(26'h800, 0), "R5 read in redirect cycle discarded",
        rd_instr[7*IW +: IW], fexp(26'h800, 0));

    // Random traffic over a narrow line range: merges, flushes, reordering
    do_reset();
    for (int i = 0; i < NT; i++) redirect(i, LW'(32'h40 + $urandom % 12));
    for (int c = 0; c < 20000; c++) begin
      for (int i = 0; i < NT; i++)
        if ($urandom % 200 == 0) redirect(i, LW'(32'h40 + $urandom % 12));
      rd_ready  = NT'($urandom);
      req_ready = ($urandom % 10) < 7;
      if (pend_n > 0 && ($urandom % 10) < 4) respond(pend_line[$urandom % pend_n]);
      tick();
    end
    chk(req_cnt > 100, "R2 random traffic made progress", 128'(req_cnt), 128'(100));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule